// File: doc/BRIEF.md
# Core Interrupt Priority Resolver

This block collects interrupt requests aimed at a processor core and decides which one the core should take next. Each of sixteen request lines has a pending bit in a latch register, set by a rising edge on its line, and an enable bit in a mask register. A global enable gates the whole set. The lowest-numbered bit that is pending, unmasked and globally enabled wins. The block presents that bit's index and its handler vector address, which is the index times 0x20.

Four system lines occupy bits 0 to 3. Bit 0 is the power-down request and has the highest priority. Bit 1 is the loop/PC-stack request, bit 2 the emulation-kernel request, and bit 3 the last system entry. Twelve user-assignable lines, user 0 to user 11, occupy bits 4 to 15, and user 11 has the lowest priority. Software reaches the latch, the mask and the enable through a small register port.

When the core takes the presented interrupt it pulses an acknowledge. This clears the winning latch bit so that the next candidate moves forward.

Top module: `irq_prio_resolver`

## Requirements
- R1: After synchronous reset, the latch, the mask and the global enable are all zero, and `irq_valid_o` is 0.
- R2: A 0-to-1 transition on a request line sets its latch bit, and the bit is visible in the cycle after the clock edge that samples the transition. A line held high sets the bit only once: after the bit is cleared, it stays clear until the line falls and rises again.
- R3: `irq_valid_o` is 1 only when the global enable is 1 and at least one bit is 1 in both the latch and the mask. Otherwise `irq_valid_o` is 0 and the vector reads 0.
- R4: When several bits are pending and unmasked, the lowest bit index wins.
- R5: `irq_vector_o` is the 24-bit value winning index × 0x20: bit 0 gives 0x000000, bit 1 gives 0x000020, bit 4 gives 0x000080 and bit 15 gives 0x0001E0.
- R6: When `ack_i` is 1 while `irq_valid_o` is 1, the latch bit of the presented index is cleared at that clock edge. Every other latch bit is unaffected.
- R7: A write to register address 0 (latch) clears each latch bit whose write-data bit is 1 and leaves the other bits unchanged.
- R8: If a rising edge on a line and a clear of the same latch bit (by software or by acknowledge) fall in the same cycle, the bit ends up set.
- R9: Register map on `reg_addr_i`:
  - address 0 reads the latch;
  - address 1 reads and writes the mask (1 = enabled);
  - address 2 holds the global enable in bit 0, with the other bits reading 0;
  - address 3 reads 0.
  Writes take effect at the clock edge where `reg_we_i` is 1. Reads are combinational.
- R10: Clearing the global enable hides all interrupts but keeps the latch contents. Setting the enable again presents the same winner.
- R11: `sys_req_i[n]` drives latch bit n for n = 0 to 3, and `usr_req_i[n]` drives latch bit n+4 for n = 0 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_req_i | input | 4 | System request lines, latch bits 0..3 |
| usr_req_i | input | 12 | User-assignable request lines, latch bits 4..15 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 latch, 1 mask, 2 enable |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for the selected register |
| ack_i | input | 1 | Core acknowledge of the presented interrupt |
| irq_valid_o | output | 1 | An interrupt is presented |
| irq_index_o | output | 4 | Bit index of the presented interrupt |
| irq_vector_o | output | 24 | Handler vector address of the presented interrupt |

## Verification
Each register bit sits one flop away from the ports, so a wrong value shows up within a cycle.
- A latch bit that sets on a held level, or that misses an edge, appears in the index and the vector in the very next cycle. It also appears in the latch read-back.
- A bad acknowledge clear is visible one cycle after the acknowledge. Either the old index stays presented, or a neighbouring bit vanishes from the read-back.
- Priority and vector faults appear at once, as soon as two bits are pending together or a bit at either end of the range (0 or 15) is taken.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    localparam int NUM_SYS      = 4;
    localparam int NUM_USR      = 12;
    localparam int NUM_LINES    = NUM_SYS + NUM_USR;
    localparam int IDX_W        = $clog2(NUM_LINES);
    localparam int VEC_W        = 24;
    localparam int STRIDE_LOG2  = 5;
    localparam int ADDR_W       = 2;

    typedef logic [NUM_LINES-1:0] line_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_LATCH = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] index;
        logic [VEC_W-1:0] vector;
    } grant_t;

    function automatic logic [VEC_W-1:0] vector_of(input logic [IDX_W-1:0] idx);
        return VEC_W'(idx) << STRIDE_LOG2;
    endfunction

    function automatic line_vec_t onehot_of(input logic [IDX_W-1:0] idx);
        return line_vec_t'(1) << idx;
    endfunction

endpackage

// File: rtl/irq_res_edge.sv
module irq_res_edge #(
    parameter int W = irq_res_pkg::NUM_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] req_i,
    output logic [W-1:0] rise_o
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= req_i[g];
        end
        assign rise_o[g] = req_i[g] & ~prev_q;
    end
endmodule

// File: rtl/irq_res_regs.sv
module irq_res_regs
    import irq_res_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we_i,
    input  reg_sel_e  sel_i,
    input  line_vec_t wdata_i,
    input  line_vec_t rise_i,
    input  line_vec_t ack_clr_i,
    output line_vec_t latch_o,
    output line_vec_t mask_o,
    output logic      en_o,
    output line_vec_t rdata_o
);
    line_vec_t latch_q, mask_q, sw_clr;
    logic      en_q;

    always_comb begin
        sw_clr = '0;
        if (we_i && sel_i == SEL_LATCH) sw_clr = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            mask_q  <= '0;
            en_q    <= 1'b0;
        end else begin
            // set dominates any clear landing in the same cycle
            latch_q <= (latch_q & ~(sw_clr | ack_clr_i)) | rise_i;
            if (we_i && sel_i == SEL_MASK) mask_q <= wdata_i;
            if (we_i && sel_i == SEL_CTRL) en_q   <= wdata_i[0];
        end
    end

    always_comb begin
        unique case (sel_i)
            SEL_LATCH: rdata_o = latch_q;
            SEL_MASK:  rdata_o = mask_q;
            SEL_CTRL:  rdata_o = line_vec_t'(en_q);
            default:   rdata_o = '0;
        endcase
    end

    assign latch_o = latch_q;
    assign mask_o  = mask_q;
    assign en_o    = en_q;
endmodule

// File: rtl/irq_res_pick.sv
module irq_res_pick
    import irq_res_pkg::*;
(
    input  line_vec_t pend_i,
    input  logic      en_i,
    output grant_t    grant_o
);
    always_comb begin
        grant_o = '0;
        // descending scan: the last hit, the lowest index, is kept
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                grant_o.valid = en_i;
                grant_o.index = IDX_W'(i);
            end
        end
        grant_o.vector = grant_o.valid ? vector_of(grant_o.index) : '0;
    end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_res_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SYS-1:0]   sys_req_i,
    input  logic [NUM_USR-1:0]   usr_req_i,
    input  logic                 reg_we_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [NUM_LINES-1:0] reg_wdata_i,
    output logic [NUM_LINES-1:0] reg_rdata_o,
    input  logic                 ack_i,
    output logic                 irq_valid_o,
    output logic [IDX_W-1:0]     irq_index_o,
    output logic [VEC_W-1:0]     irq_vector_o
);
    line_vec_t req_all, rise_vec, ack_clr, latch_q, mask_q, rdata;
    logic      en_q;
    grant_t    grant;

    assign req_all = {usr_req_i, sys_req_i};

    irq_res_edge #(.W(NUM_LINES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_all),
        .rise_o (rise_vec)
    );

    assign ack_clr = (ack_i && grant.valid) ? onehot_of(grant.index) : '0;

    irq_res_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .we_i      (reg_we_i),
        .sel_i     (reg_sel_e'(reg_addr_i)),
        .wdata_i   (reg_wdata_i),
        .rise_i    (rise_vec),
        .ack_clr_i (ack_clr),
        .latch_o   (latch_q),
        .mask_o    (mask_q),
        .en_o      (en_q),
        .rdata_o   (rdata)
    );

    irq_res_pick u_pick (
        .pend_i  (latch_q & mask_q),
        .en_i    (en_q),
        .grant_o (grant)
    );

    assign reg_rdata_o  = rdata;
    assign irq_valid_o  = grant.valid;
    assign irq_index_o  = grant.index;
    assign irq_vector_o = grant.vector;
endmodule

// File: rtl/irq_res_chk.sv
module irq_res_chk
    import irq_res_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ack_i,
    input logic             irq_valid_o,
    input logic [IDX_W-1:0] irq_index_o,
    input logic [VEC_W-1:0] irq_vector_o,
    input line_vec_t        latch_q,
    input line_vec_t        mask_q,
    input logic             en_q,
    input line_vec_t        rise_vec
);
    // R3: nothing is presented while globally disabled
    p_valid_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        irq_valid_o |-> en_q);

    // R3: enabled with an unmasked pending bit means something is presented
    p_pending_shown_r3: assert property (@(posedge clk) disable iff (rst)
        (en_q && (latch_q & mask_q) != '0) |-> irq_valid_o);

    // R4: no lower pending unmasked bit than the presented one
    p_lowest_wins_r4: assert property (@(posedge clk) disable iff (rst)
        irq_valid_o |-> (((latch_q & mask_q) &
            ((line_vec_t'(1) << irq_index_o) - line_vec_t'(1))) == '0));

    // R5: vector is stride-aligned and inside the table
    p_vector_range_r5: assert property (@(posedge clk) disable iff (rst)
        irq_valid_o |-> (irq_vector_o[STRIDE_LOG2-1:0] == '0 &&
            irq_vector_o <= VEC_W'(24'h1E0)));

    // R2: a detected rising edge is latched by the next cycle
    p_rise_latched_r2: assert property (@(posedge clk) disable iff (rst)
        (rise_vec != '0) |=> ((latch_q & $past(rise_vec)) == $past(rise_vec)));

    // R6: acknowledge clears the presented bit unless a new edge arrives
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_valid_o && !rise_vec[irq_index_o])
            |=> !latch_q[$past(irq_index_o)]);
endmodule

bind irq_prio_resolver irq_res_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ack_i        (ack_i),
    .irq_valid_o  (irq_valid_o),
    .irq_index_o  (irq_index_o),
    .irq_vector_o (irq_vector_o),
    .latch_q      (latch_q),
    .mask_q       (mask_q),
    .en_q         (en_q),
    .rise_vec     (rise_vec)
);

// File: tb/irq_prio_resolver_bench.sv
module irq_prio_resolver_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  sys_req = '0;
    logic [11:0] usr_req = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ack = 1'b0;
    logic        irq_valid;
    logic [3:0]  irq_index;
    logic [23:0] irq_vector;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_prio_resolver u_irq_prio_resolver (
        .clk(clk), .rst(rst), .sys_req_i(sys_req), .usr_req_i(usr_req),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .ack_i(ack), .irq_valid_o(irq_valid),
        .irq_index_o(irq_index), .irq_vector_o(irq_vector)
    );

    typedef struct {
        bit          is_read;
        string       req;
        logic        valid;
        logic [3:0]  index;
        logic [15:0] rdata;
    } item_t;

    item_t sb[$];

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic exp_out(string req, logic v, logic [3:0] idx);
        item_t it;
        it.is_read = 0; it.req = req; it.valid = v; it.index = idx; it.rdata = '0;
        sb.push_back(it);
        @(negedge clk); #0.1;
    endtask

    task automatic exp_rd(string req, logic [1:0] addr, logic [15:0] val);
        item_t it;
        reg_addr = addr;
        it.is_read = 1; it.req = req; it.valid = 0; it.index = 0; it.rdata = val;
        sb.push_back(it);
        @(negedge clk); #0.1;
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [1:0] addr, logic [15:0] val);
        reg_we = 1; reg_addr = addr; reg_wdata = val;
        step();
        reg_we = 0;
    endtask

    // monitor: pops expectations and compares away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (it.is_read) begin
                if (reg_rdata !== it.rdata) begin
                    failures++;
                    $display("FAIL %s rdata actual=%h expected=%h", it.req, reg_rdata, it.rdata);
                end
            end else begin
                logic [23:0] ev;
                ev = it.valid ? (24'(it.index) << 5) : 24'h0;
                if (irq_valid !== it.valid ||
                    (it.valid && irq_index !== it.index) || irq_vector !== ev) begin
                    failures++;
                    $display("FAIL %s out actual=%b/%0d/%h expected=%b/%0d/%h",
                             it.req, irq_valid, irq_index, irq_vector, it.valid, it.index, ev);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst = 0;
        step();
        // R1: reset state
        exp_out("R1", 0, 0);
        exp_rd("R1 latch", 2'd0, 16'h0000);
        exp_rd("R1 mask", 2'd1, 16'h0000);
        exp_rd("R1 ctrl", 2'd2, 16'h0000);

        wr(2'd2, 16'h0001);
        wr(2'd1, 16'hFFFF);
        exp_out("R3 no pending", 0, 0);
        exp_rd("R9 ctrl", 2'd2, 16'h0001);
        exp_rd("R9 mask", 2'd1, 16'hFFFF);
        exp_rd("R9 none", 2'd3, 16'h0000);

        // R11 / R2 / R5: user 0 -> bit 4, vector 0x80
        usr_req[0] = 1; step();
        exp_out("R11 usr0 bit4", 1, 4);

        // R4: bit 1 beats bit 4
        sys_req[1] = 1; step();
        exp_out("R4 lowest wins", 1, 1);

        // R6: acknowledge clears bit 1 only
        ack = 1; step(); ack = 0;
        exp_out("R6 ack", 1, 4);
        exp_rd("R6 latch", 2'd0, 16'h0010);

        // R2: held level does not set again
        step(); step();
        exp_rd("R2 held level", 2'd0, 16'h0010);
        sys_req = '0; usr_req = '0; step();

        // R3: masked bit hidden
        wr(2'd1, 16'hFFEF);
        exp_out("R3 masked", 0, 0);
        exp_rd("R3 latch kept", 2'd0, 16'h0010);

        // R10: global disable hides, latch kept
        wr(2'd1, 16'hFFFF);
        wr(2'd2, 16'h0000);
        exp_out("R10 disabled", 0, 0);
        exp_rd("R10 latch kept", 2'd0, 16'h0010);
        wr(2'd2, 16'h0001);
        exp_out("R10 re-enabled", 1, 4);

        // R7: write-one-to-clear
        wr(2'd0, 16'h0010);
        exp_out("R7 cleared", 0, 0);
        exp_rd("R7 latch", 2'd0, 16'h0000);

        // R8: set and clear together, set wins; R5 bit 15 -> 0x1E0
        usr_req[11] = 1;
        wr(2'd0, 16'h8000);
        exp_out("R8 set wins / R5 bit15", 1, 15);
        exp_rd("R8 latch", 2'd0, 16'h8000);

        // R5: bit 0 -> vector 0
        sys_req[0] = 1; step();
        exp_out("R5 bit0", 1, 0);
        ack = 1; step(); ack = 0;
        exp_out("R6 ack bit0", 1, 15);
        exp_rd("R6 others kept", 2'd0, 16'h8000);

        // R8: acknowledge collides with a fresh edge on the same line
        sys_req[0] = 0; step();
        wr(2'd0, 16'h8000);
        usr_req[11] = 0; step();
        sys_req[2] = 1; step();
        exp_out("R11 sys2", 1, 2);
        sys_req[2] = 0; step();
        ack = 1; sys_req[2] = 1; step(); ack = 0;
        exp_out("R8 ack vs edge", 1, 2);

        step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule